// File: doc/BRIEF.md
# Debounced Auto-Repeat PWM Level Controller

This block keeps a 6-bit setting, from 0 to 63, and drives a pulse-width-modulated output. The high time of that output in every 64-count period equals the setting. Two input styles share the setting, and a mode pin selects between them. In counting mode, every rising edge on a single strobe input adds one to the setting. Past 63 the setting rolls over to 0, so 63 strobes take it one step down. In button mode, decoded up and down requests move the setting one step per press, and the setting clamps at both ends.

A button request moves the setting only after it has stayed unchanged for a debounce interval. If the request is held after that first step, a second step follows after a longer hold delay. After that, steps repeat at a fixed interval until the request is released. All three intervals are counted in ticks of a shared timebase. The timebase divides the system clock, and its default values give 12.8 ms, 409.6 ms and 51.2 ms at a 50 MHz clock. A shutdown input clears the setting and holds the output low. The PWM duty register picks up a new setting only where a period begins, so no pulse is ever cut short or stretched.

Top module: `lvl_pwm_ctrl`

## Requirements
- R1: After reset, `level_o` is 0 and `pwm_out` is low.
- R2: With `mode_push`=0, each 0-to-1 transition of `pulse_in` that is seen at a clock edge raises `level_o` by one at that same edge. A `pulse_in` held high gives only one step.
- R3: With `mode_push`=0, a step from 63 gives 0.
- R4: With `mode_push`=1, an up request (`btn_up`=1, `btn_dn`=0) steps `level_o` up once, DEB_TICKS ticks after the request appeared. Up steps stop at 63.
- R5: With `mode_push`=1, a down request (`btn_dn`=1, `btn_up`=0) steps `level_o` down in the same way, and down steps stop at 0.
- R6: A request that changes before DEB_TICKS ticks have passed produces no step, and the debounce count restarts from zero.
- R7: While a request is held, the second step comes HOLD_TICKS ticks after the first. Each later step comes RPT_TICKS ticks after the one before.
- R8: With both buttons pressed, or neither pressed, the level does not change.
- R9: In every span of 64 PWM counts, `pwm_out` is high for exactly the number of counts given by the active duty value. Each high run starts at count 0, so a duty of 0 gives a constant low.
- R10: The duty value takes a new `level_o` only when a PWM period begins. A new level therefore shows in `pwm_out` within one period plus one count.
- R11: While `shdn`=1, `pwm_out` is low in the same cycle, and `level_o` becomes 0 at the next edge and stays 0.
- R12: `pulse_in` has no effect in button mode, and the buttons have no effect in counting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_push | input | 1 | 1 = button mode, 0 = counting mode |
| pulse_in | input | 1 | Step strobe used in counting mode |
| btn_up | input | 1 | Decoded up request |
| btn_dn | input | 1 | Decoded down request |
| shdn | input | 1 | Shutdown: clears the level and forces the output low |
| level_o | output | 6 | Current level |
| pwm_out | output | 1 | PWM output |

## Verification
A counting-mode step lands at the same edge that first samples `pulse_in` high. The bench drives at the falling edge and reads `level_o` at the next falling edge. The bench uses one system clock per tick. With that setting, a button request driven before edge E0 steps at edge E0+DEB_TICKS, the next step comes HOLD_TICKS edges later, and the rest come every RPT_TICKS edges. The bench therefore checks that the level is unchanged one cycle before each due edge and has changed one cycle after it. The PWM duty is counted over a 64-cycle window. The window opens 66 cycles after the level settles, so it falls entirely inside periods that already hold the new duty.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  localparam int LVL_W = 6;
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  typedef enum logic [1:0] {REQ_IDLE, REQ_UP, REQ_DN} req_e;
  typedef enum logic [1:0] {PH_IDLE, PH_DEB, PH_HOLD, PH_RPT} ph_e;

  // Turn the two button lines into one request; conflicting or absent presses mean idle.
  function automatic req_e decode_req(input logic up, input logic dn);
    if (up && !dn) return REQ_UP;
    if (dn && !up) return REQ_DN;
    return REQ_IDLE;
  endfunction

  // Counting-mode step: wraps past the top.
  function automatic logic [LVL_W-1:0] wrap_inc(input logic [LVL_W-1:0] v);
    return v + LVL_W'(1);
  endfunction

  // Button-mode step: clamps at both ends.
  function automatic logic [LVL_W-1:0] sat_step(input logic [LVL_W-1:0] v, input req_e d);
    if (d == REQ_UP && v != LVL_MAX) return v + LVL_W'(1);
    if (d == REQ_DN && v != '0) return v - LVL_W'(1);
    return v;
  endfunction

  // PWM compare: the output is high while the period count is below the duty.
  function automatic logic duty_on(input logic [LVL_W-1:0] cnt, input logic [LVL_W-1:0] duty);
    return cnt < duty;
  endfunction
endpackage

// File: rtl/lvl_tick.sv
module lvl_tick #(
  parameter int DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || tick_o) cnt_q <= '0;
    else                  cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/lvl_btn_seq.sv
module lvl_btn_seq
  import lvl_pkg::*;
#(
  parameter int DEB_TICKS  = 256,
  parameter int HOLD_TICKS = 8192,
  parameter int RPT_TICKS  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  req_e req,
  output logic step_o,
  output req_e dir_o
);
  localparam int M1 = (DEB_TICKS > HOLD_TICKS) ? DEB_TICKS : HOLD_TICKS;
  localparam int ML = (M1 > RPT_TICKS) ? M1 : RPT_TICKS;
  localparam int CW = $clog2(ML + 1);

  ph_e          phase_q;
  req_e         cand_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          hit;

  always_comb begin
    case (phase_q)
      PH_DEB:  lim_m1 = CW'(DEB_TICKS - 1);
      PH_HOLD: lim_m1 = CW'(HOLD_TICKS - 1);
      default: lim_m1 = CW'(RPT_TICKS - 1);
    endcase
  end

  assign hit    = tick && (phase_q != PH_IDLE) && (req == cand_q) && (cnt_q == lim_m1);
  assign step_o = en && hit;
  assign dir_o  = cand_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase_q <= PH_IDLE;
      cand_q  <= REQ_IDLE;
      cnt_q   <= '0;
    end else if (req != cand_q) begin
      cand_q  <= req;
      cnt_q   <= '0;
      phase_q <= (req == REQ_IDLE) ? PH_IDLE : PH_DEB;
    end else if (tick && phase_q != PH_IDLE) begin
      if (hit) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_DEB) ? PH_HOLD : PH_RPT;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lvl_pwm.sv
module lvl_pwm
  import lvl_pkg::*;
#(
  parameter int PRE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LVL_W-1:0] level,
  output logic             pwm_o,
  output logic             period_load_o,
  output logic [LVL_W-1:0] cnt_o,
  output logic [LVL_W-1:0] duty_o
);
  localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRE - 1);

  logic [PW-1:0]    pre_q;
  logic             strobe;
  logic [LVL_W-1:0] cnt_q;
  logic [LVL_W-1:0] duty_q;

  assign strobe        = (pre_q == PLAST);
  assign period_load_o = strobe && (cnt_q == LVL_MAX);
  assign pwm_o         = !clr && duty_on(cnt_q, duty_q);
  assign cnt_o         = cnt_q;
  assign duty_o        = duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      pre_q <= strobe ? '0 : pre_q + PW'(1);
      if (strobe) cnt_q <= cnt_q + LVL_W'(1);
      if (period_load_o) duty_q <= level;
    end
  end
endmodule

// File: rtl/lvl_pwm_ctrl.sv
module lvl_pwm_ctrl
  import lvl_pkg::*;
#(
  parameter int TICK_DIV   = 2500,
  parameter int DEB_TICKS  = 256,
  parameter int HOLD_TICKS = 8192,
  parameter int RPT_TICKS  = 1024,
  parameter int PWM_PRE    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_push,
  input  logic             pulse_in,
  input  logic             btn_up,
  input  logic             btn_dn,
  input  logic             shdn,
  output logic [LVL_W-1:0] level_o,
  output logic             pwm_out
);
  logic             tick;
  logic             pulse_q;
  logic             pulse_rise;
  logic             step_evt;
  req_e             step_dir;
  req_e             req;
  logic             period_load;
  logic [LVL_W-1:0] pwm_cnt;
  logic [LVL_W-1:0] duty_cur;
  logic [LVL_W-1:0] lvl_q;

  assign req        = decode_req(btn_up, btn_dn);
  assign pulse_rise = !mode_push && pulse_in && !pulse_q;
  assign level_o    = lvl_q;

  lvl_tick #(.DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  lvl_btn_seq #(
    .DEB_TICKS(DEB_TICKS), .HOLD_TICKS(HOLD_TICKS), .RPT_TICKS(RPT_TICKS)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .en(mode_push && !shdn), .tick(tick),
    .req(req), .step_o(step_evt), .dir_o(step_dir)
  );

  lvl_pwm #(.PRE(PWM_PRE)) pwm_i (
    .clk(clk), .rst_n(rst_n), .clr(shdn), .level(lvl_q),
    .pwm_o(pwm_out), .period_load_o(period_load), .cnt_o(pwm_cnt), .duty_o(duty_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || shdn)          lvl_q <= '0;
    else if (mode_push) begin
      if (step_evt)              lvl_q <= sat_step(lvl_q, step_dir);
    end else if (pulse_rise)     lvl_q <= wrap_inc(lvl_q);
  end
endmodule

// File: rtl/lvl_pwm_ctrl_chk.sv
module lvl_pwm_ctrl_chk
  import lvl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_push,
  input logic             pulse_in,
  input logic             btn_up,
  input logic             btn_dn,
  input logic             shdn,
  input logic [LVL_W-1:0] level_o,
  input logic             pwm_out,
  input logic             step_evt,
  input logic             period_load,
  input logic [LVL_W-1:0] pwm_cnt,
  input logic [LVL_W-1:0] duty_cur
);
  // R11
  shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> level_o == '0);

  // R2
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_push && !shdn && pulse_in && !$past(pulse_in)) |=> level_o == $past(level_o) + LVL_W'(1));

  // R4
  top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_push && !shdn && level_o == LVL_MAX) |=> level_o != '0);

  // R5
  bottom_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_push && !shdn && level_o == '0) |=> level_o != LVL_MAX);

  // R8
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_push && !shdn && btn_up == btn_dn) |=> level_o == $past(level_o));

  // R12
  push_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_push && !shdn && !step_evt) |=> level_o == $past(level_o));

  // R10
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_load && !shdn) |=> $stable(duty_cur));

  // R9
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> pwm_cnt == '0);
endmodule

bind lvl_pwm_ctrl lvl_pwm_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_push(mode_push), .pulse_in(pulse_in),
  .btn_up(btn_up), .btn_dn(btn_dn), .shdn(shdn), .level_o(level_o),
  .pwm_out(pwm_out), .step_evt(step_evt), .period_load(period_load),
  .pwm_cnt(pwm_cnt), .duty_cur(duty_cur)
);

// File: tb/lvl_pwm_ctrl_tb.sv
module lvl_pwm_ctrl_tb_top;
  localparam int DEB  = 4;
  localparam int HOLD = 10;
  localparam int RPT  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_push = 1'b0;
  logic       pulse_in = 1'b0;
  logic       btn_up = 1'b0;
  logic       btn_dn = 1'b0;
  logic       shdn = 1'b0;
  logic [5:0] level_o;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  int exp_lvl = 0;

  always #10 clk = ~clk;

  lvl_pwm_ctrl #(
    .TICK_DIV(1), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .RPT_TICKS(RPT), .PWM_PRE(1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_push(mode_push), .pulse_in(pulse_in),
    .btn_up(btn_up), .btn_dn(btn_dn), .shdn(shdn), .level_o(level_o), .pwm_out(pwm_out)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic count_high(output int highs);
    highs = 0;
    for (int k = 0; k < 64; k++) begin
      cyc(1);
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int highs;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    check("R1 level", int'(level_o), 0);
    check("R1 pwm", int'(pwm_out), 0);

    // R2 R3 R9 R10: sweep every level in counting mode and measure duty
    for (int i = 1; i <= 64; i++) begin
      pulse_in = 1'b1;
      cyc(1);
      exp_lvl = i % 64;
      check(i == 64 ? "R3 wrap" : "R2 step", int'(level_o), exp_lvl);
      pulse_in = 1'b0;
      cyc(66);
      count_high(highs);
      check("R9/R10 duty", highs, exp_lvl);
    end

    // R2: held strobe gives one step
    pulse_in = 1'b1;
    cyc(6);
    check("R2 held", int'(level_o), 1);
    pulse_in = 1'b0;
    cyc(1);

    // R11
    shdn = 1'b1;
    #1;
    check("R11 pwm low", int'(pwm_out), 0);
    cyc(1);
    check("R11 level clear", int'(level_o), 0);
    pulse_in = 1'b1;
    cyc(2);
    check("R11 held", int'(level_o), 0);
    pulse_in = 1'b0;
    shdn = 1'b0;
    cyc(1);

    // R12: strobe ignored in button mode
    mode_push = 1'b1;
    for (int k = 0; k < 5; k++) begin
      pulse_in = 1'b1; cyc(1);
      pulse_in = 1'b0; cyc(1);
    end
    check("R12 pulse ignored", int'(level_o), 0);

    // R4 R7: debounce, hold delay, repeat
    btn_up = 1'b1;
    cyc(DEB);
    check("R4 before debounce", int'(level_o), 0);
    cyc(1);
    check("R4 first step", int'(level_o), 1);
    cyc(HOLD - 1);
    check("R7 before hold", int'(level_o), 1);
    cyc(1);
    check("R7 hold step", int'(level_o), 2);
    cyc(RPT - 1);
    check("R7 before repeat", int'(level_o), 2);
    cyc(1);
    check("R7 repeat 1", int'(level_o), 3);
    cyc(RPT);
    check("R7 repeat 2", int'(level_o), 4);
    btn_up = 1'b0;
    cyc(20);
    check("R7 release", int'(level_o), 4);

    // R6: bounces shorter than debounce
    for (int k = 0; k < 4; k++) begin
      btn_up = 1'b1; cyc(DEB - 1);
      btn_up = 1'b0; cyc(1);
    end
    check("R6 bounce", int'(level_o), 4);
    btn_dn = 1'b1; cyc(DEB - 1);
    btn_dn = 1'b0; btn_up = 1'b1; cyc(DEB);
    check("R6 restart", int'(level_o), 4);
    cyc(1);
    check("R6 after restart", int'(level_o), 5);
    btn_up = 1'b0;
    cyc(2);

    // R8
    btn_up = 1'b1; btn_dn = 1'b1;
    cyc(40);
    check("R8 both", int'(level_o), 5);
    btn_up = 1'b0; btn_dn = 1'b0;
    cyc(40);
    check("R8 idle", int'(level_o), 5);

    // R4 clamp at top
    btn_up = 1'b1;
    cyc(DEB + 1 + HOLD + RPT * 80);
    check("R4 clamp", int'(level_o), 63);
    btn_up = 1'b0;
    cyc(2);

    // R5: first down step timing, then clamp at bottom
    btn_dn = 1'b1;
    cyc(DEB);
    check("R5 before debounce", int'(level_o), 63);
    cyc(1);
    check("R5 first step", int'(level_o), 62);
    cyc(HOLD + RPT * 80);
    check("R5 clamp", int'(level_o), 0);
    btn_dn = 1'b0;
    cyc(2);

    // R12: buttons ignored in counting mode
    mode_push = 1'b0;
    btn_up = 1'b1;
    cyc(50);
    check("R12 button ignored", int'(level_o), 0);
    btn_up = 1'b0;
    pulse_in = 1'b1; cyc(1);
    check("R12 strobe active", int'(level_o), 1);
    pulse_in = 1'b0; cyc(1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule